// File: doc/BRIEF.md
# Harmonic Decoupling Network for Grid Synchronisation

This block sits between the quadrature signal generator and the phase-tracking loop of a single-phase grid synchroniser. For each input sample it takes the stationary-frame voltage vector (alpha, beta) and estimates the fundamental and the odd low-order harmonics. The tracked orders are n = 2k+1 for k = 0 .. NORD-1. With the default of seven orders these are n = 1, 3, 5, 7, 9, 11 and 13.

Every order k runs the same steps:
- It takes the input vector and removes the sum of the last filtered stationary-frame estimates of all the other orders.
- It rotates the remainder into a frame spinning at that order's signed speed.
- It applies a first-order low-pass filter to each axis in that frame.
- It rotates the filtered vector back to the stationary frame. The result is the order's new estimate.

One shared rotator/filter datapath handles the orders one after another, one order per clock. An external lookup supplies the cosine and sine of n·θ for the order named by `trig_ord`, in the same cycle. The fundamental's filtered vector in its own rotating frame is the output, in d and q components, and is flagged by a one-cycle `done`.

Top module: `harm_decoupler`

## Requirements
- R1: After a synchronous active-high reset:
  - `fund_d`, `fund_q` and `done` are zero.
  - `trig_ord` is zero.
  - All filter states and estimates are zero, so the first sample is processed against zero estimates.
- R2: A sample is accepted on a clock edge where `in_valid` is high and the block is idle. The block then processes the orders during the next NORD edges. `done` is high for exactly one cycle, after the NORD-th of those edges.
- R3: During processing, `trig_ord` counts 0, 1, … NORD-1, one step per cycle, and selects order n = 2·trig_ord+1. Outside processing, `trig_ord` is 0.
- R4: Order k's pre-filter vector is the accepted input minus the sum of the estimates of all orders other than k. Every estimate in that sum is the value left by the previous sample.
- R5: Rotation direction:
  - Order k uses angle φ = s·n·θ, with s = +1 when k is even (n = 1, 5, 9, 13) and s = −1 when k is odd (n = 3, 7, 11).
  - `trig_cos`/`trig_sin` carry cos(nθ) and sin(nθ) as signed values with 2^(TW−1) representing 1.
  - The forward rotation is d = cosφ·x + sinφ·y and q = cosφ·y − sinφ·x.
  - The forward result is shifted right arithmetically by TW−1−F, so F fraction bits are kept. It is saturated to W+6+F bits.
- R6: Each rotating-frame axis is updated as y ← sat(y + ((ALPHA·(x − y)) >>> AF)), with the gain a = ALPHA/2^AF.
- R7: The inverse rotation is α = cosφ·d − sinφ·q and β = sinφ·d + cosφ·q. The result is shifted right arithmetically by TW−1+F and saturated to W bits before it is stored as the order's estimate.
- R8: `fund_d`/`fund_q` are the order-1 filter states shifted right by F and saturated to W bits. They change only on the edge that raises `done`.
- R9: `in_valid` and the sample inputs are ignored while a sample is being processed.
- R10: Input is a fundamental of amplitude A rotating forward, plus harmonics of orders 3 and 5 rotating in their signed directions. After settling, `fund_d` is within 5 % of A and `fund_q` is within 5 % of A of zero. With a pure third harmonic and no fundamental, both outputs settle near zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| in_alpha | input | W | Stationary-frame alpha component, signed |
| in_beta | input | W | Stationary-frame beta component, signed |
| trig_ord | output | $clog2(NORD) | Index of the order whose trigonometric values are requested |
| trig_cos | input | TW | cos(n·θ) for the requested order, signed |
| trig_sin | input | TW | sin(n·θ) for the requested order, signed |
| fund_d | output | W | Fundamental estimate, d axis of its rotating frame |
| fund_q | output | W | Fundamental estimate, q axis of its rotating frame |
| done | output | 1 | One-cycle strobe: new fundamental estimate ready |

## Verification
The bench builds the block with W = 16, TW = 16, F = 8, NORD = 7 and AF = 16, but sets ALPHA to 4096 (a = 1/16) instead of the slow default. With this gain the cross-coupled filters settle within a few hundred samples. That brings convergence under mixed harmonics, rejection of a pure reverse-rotating third harmonic, and recovery after full-scale saturating inputs all within a short run. A bit-exact behavioural model of the fixed-point recurrence is compared against the outputs each cycle of every sample. Junk strobes injected during processing check that busy-time inputs are ignored.

// File: rtl/hdn_pkg.sv
package hdn_pkg;

  // Clamp a wide signed value into a w-bit signed range.
  function automatic logic signed [63:0] sat64(logic signed [63:0] v, int w);
    logic signed [63:0] hi;
    logic signed [63:0] lo;
    hi = (64'sd1 <<< (w - 1)) - 64'sd1;
    lo = -hi - 64'sd1;
    if (v > hi)      return hi;
    else if (v < lo) return lo;
    else             return v;
  endfunction

  // Rotation direction of order index k (n = 2k+1): +1 for even k, -1 for odd k.
  function automatic logic order_is_reverse(int unsigned k);
    return (k % 2) == 1;
  endfunction

endpackage

// File: rtl/hdn_seq.sv
module hdn_seq #(
  parameter int NORD = 7,
  parameter int OIW  = $clog2(NORD)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start_req,
  output logic           accept,
  output logic           busy,
  output logic [OIW-1:0] idx,
  output logic           last,
  output logic           done
);

  localparam logic [OIW-1:0] LAST_IDX = OIW'(NORD - 1);

  assign accept = start_req && !busy;
  assign last   = busy && (idx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      idx  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start_req) begin
          busy <= 1'b1;
          idx  <= '0;
        end
      end else if (last) begin
        busy <= 1'b0;
        idx  <= '0;
        done <= 1'b1;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    busy |-> idx <= LAST_IDX); // R3
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
    (busy && !last) |=> (busy && idx == $past(idx) + 1'b1)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R2
  AST_LAST_DONE: assert property (@(posedge clk) disable iff (rst)
    last |=> (done && !busy)); // R2

endmodule

// File: rtl/hdn_rotate.sv
module hdn_rotate #(
  parameter int IW      = 21,
  parameter int CW      = 17,
  parameter int OW      = 30,
  parameter int SHIFT   = 7,
  parameter bit INVERSE = 1'b0
) (
  input  logic signed [IW-1:0] x_i,
  input  logic signed [IW-1:0] y_i,
  input  logic signed [CW-1:0] c_i,
  input  logic signed [CW-1:0] s_i,
  output logic signed [OW-1:0] x_o,
  output logic signed [OW-1:0] y_o
);

  logic signed [63:0] xe, ye, ce, se;
  logic signed [63:0] px, py;

  assign xe = 64'(x_i);
  assign ye = 64'(y_i);
  assign ce = 64'(c_i);
  assign se = 64'(s_i);

  generate
    if (INVERSE) begin : g_inv
      always_comb begin
        px = ce * xe - se * ye;
        py = se * xe + ce * ye;
      end
    end else begin : g_fwd
      always_comb begin
        px = ce * xe + se * ye;
        py = ce * ye - se * xe;
      end
    end
  endgenerate

  assign x_o = OW'(hdn_pkg::sat64(px >>> SHIFT, OW));
  assign y_o = OW'(hdn_pkg::sat64(py >>> SHIFT, OW));

endmodule

// File: rtl/hdn_lpf.sv
module hdn_lpf #(
  parameter int YW    = 30,
  parameter int ALPHA = 858,
  parameter int AF    = 16
) (
  input  logic signed [YW-1:0] x_i,
  input  logic signed [YW-1:0] y_i,
  output logic signed [YW-1:0] y_o
);

  localparam logic signed [63:0] GAIN = 64'(ALPHA);

  logic signed [63:0] diff, step, sum;

  always_comb begin
    diff = 64'(x_i) - 64'(y_i);
    step = (GAIN * diff) >>> AF;
    sum  = 64'(y_i) + step;
  end

  assign y_o = YW'(hdn_pkg::sat64(sum, YW));

endmodule

// File: rtl/harm_decoupler.sv
module harm_decoupler #(
  parameter int W     = 16,
  parameter int TW    = 16,
  parameter int NORD  = 7,
  parameter int F     = 8,
  parameter int AF    = 16,
  parameter int ALPHA = 858,
  localparam int OIW  = $clog2(NORD)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [W-1:0]  in_alpha,
  input  logic signed [W-1:0]  in_beta,
  output logic [OIW-1:0]       trig_ord,
  input  logic signed [TW-1:0] trig_cos,
  input  logic signed [TW-1:0] trig_sin,
  output logic signed [W-1:0]  fund_d,
  output logic signed [W-1:0]  fund_q,
  output logic                 done
);

  localparam int SW  = W + 3;      // sum of NORD estimates
  localparam int XW  = W + 5;      // pre-filter vector
  localparam int YW  = W + 6 + F;  // rotating-frame filter state
  localparam int CW  = TW + 1;     // signed trig after direction
  localparam int FSH = TW - 1 - F;
  localparam int ISH = TW - 1 + F;

  // sequencing
  logic           accept, busy, last;
  logic [OIW-1:0] idx;

  hdn_seq #(.NORD(NORD), .OIW(OIW)) u_seq (
    .clk(clk), .rst(rst), .start_req(in_valid),
    .accept(accept), .busy(busy), .idx(idx), .last(last), .done(done)
  );

  assign trig_ord = idx;

  // state
  logic signed [W-1:0]  cap_a, cap_b;
  logic signed [SW-1:0] sum_a, sum_b;
  logic signed [SW-1:0] acc_a, acc_b;
  logic signed [W-1:0]  est_a [NORD];
  logic signed [W-1:0]  est_b [NORD];
  logic signed [YW-1:0] flt_d [NORD];
  logic signed [YW-1:0] flt_q [NORD];

  // per-order datapath
  logic signed [CW-1:0] c_eff, s_eff;
  logic signed [XW-1:0] x_a, x_b;
  logic signed [YW-1:0] rot_d, rot_q;
  logic signed [YW-1:0] new_d, new_q;
  logic signed [W-1:0]  new_a, new_b;

  always_comb begin
    c_eff = CW'(trig_cos);
    s_eff = hdn_pkg::order_is_reverse(32'(idx)) ? -CW'(trig_sin) : CW'(trig_sin);
    x_a   = XW'(cap_a) - XW'(sum_a) + XW'(est_a[idx]);
    x_b   = XW'(cap_b) - XW'(sum_b) + XW'(est_b[idx]);
  end

  hdn_rotate #(.IW(XW), .CW(CW), .OW(YW), .SHIFT(FSH), .INVERSE(1'b0)) u_park (
    .x_i(x_a), .y_i(x_b), .c_i(c_eff), .s_i(s_eff), .x_o(rot_d), .y_o(rot_q)
  );

  logic signed [YW-1:0] lpf_in  [2];
  logic signed [YW-1:0] lpf_st  [2];
  logic signed [YW-1:0] lpf_out [2];

  assign lpf_in[0] = rot_d;
  assign lpf_in[1] = rot_q;
  assign lpf_st[0] = flt_d[idx];
  assign lpf_st[1] = flt_q[idx];

  generate
    for (genvar ax = 0; ax < 2; ax++) begin : g_axis
      hdn_lpf #(.YW(YW), .ALPHA(ALPHA), .AF(AF)) u_lpf (
        .x_i(lpf_in[ax]), .y_i(lpf_st[ax]), .y_o(lpf_out[ax])
      );
    end
  endgenerate

  assign new_d = lpf_out[0];
  assign new_q = lpf_out[1];

  hdn_rotate #(.IW(YW), .CW(CW), .OW(W), .SHIFT(ISH), .INVERSE(1'b1)) u_ipark (
    .x_i(new_d), .y_i(new_q), .c_i(c_eff), .s_i(s_eff), .x_o(new_a), .y_o(new_b)
  );

  // register updates
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_a  <= '0;
      cap_b  <= '0;
      sum_a  <= '0;
      sum_b  <= '0;
      acc_a  <= '0;
      acc_b  <= '0;
      fund_d <= '0;
      fund_q <= '0;
      for (int k = 0; k < NORD; k++) begin
        est_a[k] <= '0;
        est_b[k] <= '0;
        flt_d[k] <= '0;
        flt_q[k] <= '0;
      end
    end else begin
      if (accept) begin
        cap_a <= in_alpha;
        cap_b <= in_beta;
        acc_a <= '0;
        acc_b <= '0;
      end
      if (busy) begin
        est_a[idx] <= new_a;
        est_b[idx] <= new_b;
        flt_d[idx] <= new_d;
        flt_q[idx] <= new_q;
        if (last) begin
          sum_a  <= acc_a + SW'(new_a);
          sum_b  <= acc_b + SW'(new_b);
          fund_d <= W'(hdn_pkg::sat64(64'(flt_d[0]) >>> F, W));
          fund_q <= W'(hdn_pkg::sat64(64'(flt_q[0]) >>> F, W));
        end else begin
          acc_a <= acc_a + SW'(new_a);
          acc_b <= acc_b + SW'(new_b);
        end
      end
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !last |=> ($stable(fund_d) && $stable(fund_q))); // R8
  AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(cap_a) && $stable(cap_b))); // R9
  AST_IDLE_ORDER: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (trig_ord == '0)); // R3
  AST_START_ORDER: assert property (@(posedge clk) disable iff (rst)
    accept |=> (busy && trig_ord == '0)); // R2

endmodule

// File: tb/tb_harm_decoupler.sv
module tb_harm_decoupler;

  localparam int W = 16, TW = 16, NORD = 7, F = 8, AF = 16, ALPHA = 4096;
  localparam int YW = W + 6 + F;
  localparam real PI = 3.14159265358979;

  logic clk = 0;
  logic rst = 1;
  logic in_valid = 0;
  logic signed [W-1:0] in_alpha = '0, in_beta = '0;
  logic [2:0] trig_ord;
  logic signed [TW-1:0] trig_cos, trig_sin;
  logic signed [W-1:0] fund_d, fund_q;
  logic done;

  always #5 clk = ~clk;

  harm_decoupler #(.W(W), .TW(TW), .NORD(NORD), .F(F), .AF(AF), .ALPHA(ALPHA)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_alpha(in_alpha), .in_beta(in_beta),
    .trig_ord(trig_ord), .trig_cos(trig_cos), .trig_sin(trig_sin),
    .fund_d(fund_d), .fund_q(fund_q), .done(done)
  );

  int n_tests = 0, n_fail = 0;
  longint ct[NORD], st[NORD];
  longint me_a[NORD], me_b[NORD], myd[NORD], myq[NORD];
  longint exp_d = 0, exp_q = 0;

  always_comb begin
    trig_cos = (trig_ord < 3'(NORD)) ? TW'(ct[trig_ord]) : '0;
    trig_sin = (trig_ord < 3'(NORD)) ? TW'(st[trig_ord]) : '0;
  end

  function automatic longint msat(longint v, int w);
    longint hi = (64'sd1 <<< (w - 1)) - 1;
    if (v > hi) return hi;
    if (v < -hi - 1) return -hi - 1;
    return v;
  endfunction

  function automatic longint rnd(real x);
    return (x >= 0.0) ? longint'($rtoi(x + 0.5)) : -longint'($rtoi(-x + 0.5));
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic set_angle(input real th);
    for (int k = 0; k < NORD; k++) begin
      ct[k] = rnd(32767.0 * $cos(real'(2 * k + 1) * th));
      st[k] = rnd(32767.0 * $sin(real'(2 * k + 1) * th));
    end
  endtask

  // Behavioural reference of one sample, from the fixed-point requirements.
  task automatic model(input longint a, input longint b);
    longint sa = 0, sb = 0;
    for (int m = 0; m < NORD; m++) begin sa += me_a[m]; sb += me_b[m]; end
    for (int k = 0; k < NORD; k++) begin
      longint c = ct[k];
      longint s = (k % 2 == 1) ? -st[k] : st[k];
      longint xa = a - sa + me_a[k];
      longint xb = b - sb + me_b[k];
      longint d = msat((c * xa + s * xb) >>> (TW - 1 - F), YW);
      longint q = msat((c * xb - s * xa) >>> (TW - 1 - F), YW);
      myd[k] = msat(myd[k] + ((longint'(ALPHA) * (d - myd[k])) >>> AF), YW);
      myq[k] = msat(myq[k] + ((longint'(ALPHA) * (q - myq[k])) >>> AF), YW);
      me_a[k] = msat((c * myd[k] - s * myq[k]) >>> (TW - 1 + F), W);
      me_b[k] = msat((s * myd[k] + c * myq[k]) >>> (TW - 1 + F), W);
    end
    exp_d = msat(myd[0] >>> F, W);
    exp_q = msat(myq[0] >>> F, W);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; in_valid = 0;
    repeat (3) @(negedge clk);
    for (int k = 0; k < NORD; k++) begin me_a[k] = 0; me_b[k] = 0; myd[k] = 0; myq[k] = 0; end
    exp_d = 0; exp_q = 0;
    rst = 0;
  endtask

  task automatic run_sample(input longint a, input longint b, input bit junk, input string tag);
    @(negedge clk);
    in_valid = 1; in_alpha = W'(a); in_beta = W'(b);
    @(negedge clk);
    check(trig_ord == 0 && done == 0, "R3", longint'(trig_ord), 0);
    if (junk) begin
      in_valid = 1; in_alpha = W'($urandom); in_beta = W'($urandom);
    end else in_valid = 0;
    for (int j = 1; j < NORD; j++) begin
      @(negedge clk);
      check(done == 0, "R2", longint'(done), 0);
      check(trig_ord == 3'(j), "R3", longint'(trig_ord), j);
      if (j == NORD - 1) in_valid = 0;
    end
    @(negedge clk);
    model(a, b);
    check(done == 1, "R2", longint'(done), 1);
    check(longint'(fund_d) == exp_d, {tag, " d"}, longint'(fund_d), exp_d);
    check(longint'(fund_q) == exp_q, {tag, " q"}, longint'(fund_q), exp_q);
    @(negedge clk);
    check(done == 0, "R2", longint'(done), 0);
    check(longint'(fund_d) == exp_d && longint'(fund_q) == exp_q, "R8", longint'(fund_d), exp_d);
  endtask

  function automatic longint absl(longint v);
    return (v < 0) ? -v : v;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    real th;
    set_angle(0.0);
    do_reset();
    @(negedge clk);
    // R1 reset state
    check(fund_d == 0 && fund_q == 0, "R1", longint'(fund_d), 0);
    check(done == 0 && trig_ord == 0, "R1", longint'(done), 0);

    // R1/R6 first sample against zero state: d = floor(floor(32767*1000/128)*4096/65536)>>8 = 62
    set_angle(0.0);
    run_sample(1000, 0, 0, "R6");
    check(fund_d == 62, "R6", longint'(fund_d), 62);
    check(fund_q == 0, "R6", longint'(fund_q), 0);

    // R4/R10 mixed harmonics, fundamental 8000, 3rd (reverse) 1200, 5th (forward) 900
    do_reset();
    for (int i = 0; i < 400; i++) begin
      real a, b;
      th = 2.0 * PI * real'(i) / 40.0;
      set_angle(th);
      a = 8000.0 * $cos(th) + 1200.0 * $cos(3.0 * th) + 900.0 * $cos(5.0 * th);
      b = 8000.0 * $sin(th) - 1200.0 * $sin(3.0 * th) + 900.0 * $sin(5.0 * th);
      run_sample(rnd(a), rnd(b), 0, "R4");
    end
    check(absl(longint'(fund_d) - 8000) < 400, "R10", longint'(fund_d), 8000);
    check(absl(longint'(fund_q)) < 400, "R10", longint'(fund_q), 0);

    // R9 junk strobes during processing are ignored
    for (int i = 400; i < 420; i++) begin
      th = 2.0 * PI * real'(i) / 40.0;
      set_angle(th);
      run_sample(rnd(8000.0 * $cos(th)), rnd(8000.0 * $sin(th)), 1, "R9");
    end

    // R7 full-scale inputs drive saturation
    for (int i = 0; i < 30; i++) begin
      th = 2.0 * PI * real'(i) / 7.0;
      set_angle(th);
      run_sample((i % 2 == 0) ? 32767 : -32768, (i % 3 == 0) ? -32768 : 32767, 0, "R7");
    end

    // R5 pure reverse-rotating third harmonic leaves the fundamental near zero
    do_reset();
    for (int i = 0; i < 300; i++) begin
      th = 2.0 * PI * real'(i) / 40.0;
      set_angle(th);
      run_sample(rnd(6000.0 * $cos(3.0 * th)), rnd(-6000.0 * $sin(3.0 * th)), 0, "R5");
    end
    check(absl(longint'(fund_d)) < 300, "R5", longint'(fund_d), 0);
    check(absl(longint'(fund_q)) < 300, "R5", longint'(fund_q), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule